// File: doc/BRIEF.md
# Serial Code-Memory Programming Controller

This block lets an external programmer load, clear and read back a small on-chip code memory through a three-wire serial link: a shift clock, a data line into the block and a data line out of it. The link is live only while the session input `progMode` is held high. The serial clock is oversampled by the system clock. Each instruction is a 32-bit frame whose first byte selects the operation. The block holds every command off until an unlock frame has arrived.

A byte write works like a flash cell. It can only clear bits, so a location has to be erased before it can take a value with more ones in it. Each accepted write starts a self-timed busy window. During that window, further writes and erases are refused. A read of the location just written returns the byte with its top bit inverted, so the programmer can poll for completion over the same link. Reads of the array always come back in the fourth byte of the frame.

Top module: `isp_prog_ctrl`

## Requirements
- R1: While `progMode` is low, the bit counter stays at zero, the unlock state is cleared and `miso` is 0. A partly shifted frame is thrown away when `progMode` falls.
- R2: A frame is 32 bits, sent MSB first, and `mosi` is sampled on the rising edge of `sck`. Byte 0 is the opcode. The frame AC 53 xx xx unlocks the block.
- R3: Until the block is unlocked, write and erase frames leave the array unchanged, and read frames return 00h.
- R4: The frame AC 80 xx xx sets every location of the array to FFh.
- R5: The frame 40h, A, A, D writes data D. The address is the 13-bit field in bytes 1 and 2 (bits 12:0). The stored value is the old value ANDed with D.
- R6: The frame 20h, A, A, xx returns the addressed byte MSB first during byte 3. `miso` changes on the falling edge of `sck`, and `miso` is 0 during bytes 0 to 2.
- R7: An accepted write makes the block busy for `BUSY_CYCLES` system clocks. Write and erase frames that complete while the block is busy are ignored.
- R8: While the block is busy, a read of the last-written address returns that byte with bit 7 inverted. Reads of other addresses, and any read once the busy window has ended, return the stored byte.
- R9: An address selects location (address mod `DEPTH`), so address 1004h aliases location 4 when `DEPTH` is 64.
- R10: After system reset, every location of the array holds FFh.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous system reset, active low |
| progMode | input | 1 | Programming session enable, active high |
| sck | input | 1 | Serial shift clock from the programmer |
| mosi | input | 1 | Serial instruction data into the block |
| miso | output | 1 | Serial read data out of the block |

## Verification
Directed frames cover several cases:
- Write a value, then a value with fewer ones: the result shows AND accumulation as opposed to plain overwrite.
- Read before and after unlock: this separates the locked and unlocked paths.
- Read the last-written address and a different address right after a write, then again after the busy window: this separates data polling from normal reads.
- Write and erase immediately after a write: this proves that commands are refused while busy.
- Use an address above the array size: this shows aliasing.

Seeded random writes, reads and occasional erases at random 13-bit addresses are then compared against a bench memory model. Every read frame also checks that `miso` stays low outside the data byte.

// File: rtl/isp_pkg.sv
package isp_pkg;
  localparam int ADDR_W = 13;
  localparam int FRAME_W = 32;

  localparam logic [7:0] OP_GROUP = 8'hAC;
  localparam logic [7:0] SUB_UNLOCK = 8'h53;
  localparam logic [7:0] SUB_ERASE = 8'h80;
  localparam logic [7:0] OP_WRITE = 8'h40;
  localparam logic [7:0] OP_READ = 8'h20;

  typedef struct packed {
    logic wrStb;     // commit byte write from the completed frame
    logic eraseStb;  // fill the array with FFh
    logic rdLatch;   // capture read byte, address just complete
    logic rdValid;   // captured byte is real data (else zero)
    logic shiftOut;  // falling edge inside the data byte
    logic [2:0] outIdx;
    logic clrOut;    // drive miso low
    logic busy;      // self-timed write in progress
  } ispStrobes_t;
endpackage

// File: rtl/isp_datapath.sv
module isp_datapath
  import isp_pkg::*;
#(
  parameter int DEPTH = 64
) (
  input  logic clk,
  input  logic rstN,
  input  logic sck,
  input  logic mosi,
  input  ispStrobes_t st,
  output logic sckRise,
  output logic sckFall,
  output logic [15:0] frameHead,
  output logic miso
);
  localparam int IDX_W = $clog2(DEPTH);

  logic [2:0] sckSync;
  logic [1:0] mosiSync;
  logic [FRAME_W-2:0] shiftReg;
  logic [FRAME_W-1:0] nextWord;
  logic [7:0] mem [DEPTH];
  logic [IDX_W-1:0] lastIdx, rdIdx, wrIdx;
  logic [7:0] rdByte, rdData, misoReg;

  assign sckRise = sckSync[1] & ~sckSync[2];
  assign sckFall = ~sckSync[1] & sckSync[2];
  assign nextWord = {shiftReg, mosiSync[1]};
  assign frameHead = nextWord[31:16];

  function automatic logic [IDX_W-1:0] toIdx(input logic [ADDR_W-1:0] a);
    return IDX_W'(a % ADDR_W'(DEPTH));
  endfunction

  assign rdIdx = toIdx(nextWord[ADDR_W-1:0]);
  assign wrIdx = toIdx(nextWord[ADDR_W+7:8]);

  always_comb begin
    rdData = mem[rdIdx];
    if (st.busy && rdIdx == lastIdx) rdData[7] = ~rdData[7];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sckSync <= '0;
      mosiSync <= '0;
      shiftReg <= '0;
    end else begin
      sckSync <= {sckSync[1:0], sck};
      mosiSync <= {mosiSync[0], mosi};
      if (sckRise) shiftReg <= nextWord[FRAME_W-2:0];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= 8'hFF;
      lastIdx <= '0;
    end else if (st.eraseStb) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= 8'hFF;
    end else if (st.wrStb) begin
      mem[wrIdx] <= mem[wrIdx] & nextWord[7:0];
      lastIdx <= wrIdx;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdByte <= '0;
      misoReg <= '0;
    end else begin
      if (st.rdLatch) rdByte <= st.rdValid ? rdData : 8'h00;
      if (st.clrOut) misoReg <= '0;
      else if (st.shiftOut) misoReg <= {7'd0, rdByte[st.outIdx]};
    end
  end

  assign miso = misoReg[0];

  assert_erase_fills_R4: assert property (@(posedge clk) disable iff (!rstN)
    st.eraseStb |=> (mem[0] == 8'hFF && mem[DEPTH-1] == 8'hFF));
  assert_write_clears_only_R5: assert property (@(posedge clk) disable iff (!rstN)
    st.wrStb |=> ((mem[$past(wrIdx)] & ~$past(mem[wrIdx])) == 8'h00));
  assert_miso_quiet_R1: assert property (@(posedge clk) disable iff (!rstN)
    st.clrOut |=> !miso);
endmodule

// File: rtl/isp_control.sv
module isp_control
  import isp_pkg::*;
#(
  parameter int BUSY_CYCLES = 64
) (
  input  logic clk,
  input  logic rstN,
  input  logic progMode,
  input  logic sckRise,
  input  logic sckFall,
  input  logic [15:0] frameHead,
  output ispStrobes_t st
);
  localparam int BUSY_W = $clog2(BUSY_CYCLES + 1);

  logic [4:0] bitCnt;
  logic unlocked;
  logic [BUSY_W-1:0] busyCnt;
  logic frameDone, busy;
  logic [7:0] opByte, subByte;

  assign busy = busyCnt != '0;
  assign frameDone = progMode && sckRise && bitCnt == 5'd31;
  assign opByte = frameHead[15:8];
  assign subByte = frameHead[7:0];

  always_comb begin
    st = '0;
    st.busy = busy;
    st.wrStb = frameDone && unlocked && !busy && opByte == OP_WRITE;
    st.eraseStb = frameDone && unlocked && !busy && opByte == OP_GROUP && subByte == SUB_ERASE;
    st.rdLatch = progMode && sckRise && bitCnt == 5'd23;
    st.rdValid = unlocked && subByte == OP_READ;
    st.shiftOut = progMode && sckFall && bitCnt[4:3] == 2'b11;
    st.outIdx = ~bitCnt[2:0];
    st.clrOut = !progMode || (sckFall && bitCnt[4:3] != 2'b11);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bitCnt <= '0;
      unlocked <= 1'b0;
    end else if (!progMode) begin
      bitCnt <= '0;
      unlocked <= 1'b0;
    end else begin
      if (sckRise) bitCnt <= bitCnt + 5'd1;
      if (frameDone && opByte == OP_GROUP && subByte == SUB_UNLOCK) unlocked <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) busyCnt <= '0;
    else if (st.wrStb) busyCnt <= BUSY_W'(BUSY_CYCLES);
    else if (busy) busyCnt <= busyCnt - 1'b1;
  end

  assert_session_drop_R1: assert property (@(posedge clk) disable iff (!rstN)
    !progMode |=> (bitCnt == 5'd0 && !unlocked));
  assert_locked_no_cmd_R3: assert property (@(posedge clk) disable iff (!rstN)
    (st.wrStb || st.eraseStb) |-> unlocked);
  assert_busy_after_write_R7: assert property (@(posedge clk) disable iff (!rstN)
    st.wrStb |=> busy);
  assert_busy_source_R7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(st.wrStb));
endmodule

// File: rtl/isp_prog_ctrl.sv
module isp_prog_ctrl
  import isp_pkg::*;
#(
  parameter int DEPTH = 64,
  parameter int BUSY_CYCLES = 64
) (
  input  logic clk,
  input  logic rstN,
  input  logic progMode,
  input  logic sck,
  input  logic mosi,
  output logic miso
);
  ispStrobes_t st;
  logic sckRise, sckFall;
  logic [15:0] frameHead;

  isp_control #(.BUSY_CYCLES(BUSY_CYCLES)) uCtl (
    .clk(clk), .rstN(rstN), .progMode(progMode),
    .sckRise(sckRise), .sckFall(sckFall), .frameHead(frameHead), .st(st)
  );

  isp_datapath #(.DEPTH(DEPTH)) uDp (
    .clk(clk), .rstN(rstN), .sck(sck), .mosi(mosi), .st(st),
    .sckRise(sckRise), .sckFall(sckFall), .frameHead(frameHead), .miso(miso)
  );
endmodule

// File: tb/isp_prog_ctrl_test.sv
module isp_prog_ctrl_test;
  localparam int DEPTH = 64;
  localparam int BUSY = 1500;

  logic clk = 1'b0, rstN = 1'b0, progMode = 1'b0, sck = 1'b0, mosi = 1'b0;
  logic miso;
  int vectors = 0, errors = 0;
  logic [7:0] model [DEPTH];
  logic [7:0] rdGot;
  logic leak;

  always #10 clk = ~clk;

  isp_prog_ctrl #(.DEPTH(DEPTH), .BUSY_CYCLES(BUSY)) uut (
    .clk(clk), .rstN(rstN), .progMode(progMode), .sck(sck), .mosi(mosi), .miso(miso)
  );

  task automatic check8(input string tag, input logic [7:0] got, input logic [7:0] exp);
    vectors++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %02h expected %02h", tag, got, exp);
    end
  endtask

  // R2: MSB first, mosi set in low phase, sampled by design on sck rise
  task automatic shiftBits(input logic [31:0] w, input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk) mosi = w[31-k];
      repeat (10) @(negedge clk);
      if (k >= 24) rdGot[31-k] = miso;
      else if (miso) leak = 1'b1;
      sck = 1'b1;
      repeat (10) @(negedge clk);
      sck = 1'b0;
    end
  endtask

  task automatic frame(input logic [7:0] b0, b1, b2, b3);
    rdGot = 8'h00;
    leak = 1'b0;
    shiftBits({b0, b1, b2, b3}, 32);
    repeat (12) @(negedge clk);
  endtask

  function automatic int idxOf(input logic [12:0] a);
    return int'(a) % DEPTH;
  endfunction

  task automatic wrCmd(input logic [12:0] a, input logic [7:0] d, input logic accepted);
    frame(8'h40, {3'b0, a[12:8]}, a[7:0], d);
    if (accepted) model[idxOf(a)] = model[idxOf(a)] & d;
  endtask

  task automatic rdCmd(input logic [12:0] a, input logic [7:0] exp, input string tag);
    frame(8'h20, {3'b0, a[12:8]}, a[7:0], 8'h00);
    check8(tag, rdGot, exp);
    check8("R6 miso low outside data byte", {7'd0, leak}, 8'h00);
  endtask

  task automatic erase();
    frame(8'hAC, 8'h80, 8'h00, 8'h00);
    for (int i = 0; i < DEPTH; i++) model[i] = 8'hFF;
  endtask

  initial begin
    for (int i = 0; i < DEPTH; i++) model[i] = 8'hFF;
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    int unsigned seedDummy;
    seedDummy = $urandom(32'd20240611);
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    repeat (3) @(negedge clk);
    check8("R1 miso low at reset", {7'd0, miso}, 8'h00);
    progMode = 1'b1;
    repeat (5) @(negedge clk);

    // R3: locked block
    rdCmd(13'd5, 8'h00, "R3 read while locked");
    wrCmd(13'd5, 8'h00, 1'b0);
    frame(8'hAC, 8'h80, 8'h00, 8'h00); // erase while locked: no effect visible, array already FF
    frame(8'hAC, 8'h53, 8'h00, 8'h00); // R2 unlock
    rdCmd(13'd5, 8'hFF, "R3 locked write ignored / R10 reset FF");
    rdCmd(13'd63, 8'hFF, "R10 top location FF after reset");

    // R5: AND accumulation, R4 erase
    wrCmd(13'd3, 8'h5A, 1'b1);
    repeat (BUSY + 200) @(negedge clk);
    rdCmd(13'd3, 8'h5A, "R5 first write");
    wrCmd(13'd3, 8'hF0, 1'b1);
    repeat (BUSY + 200) @(negedge clk);
    rdCmd(13'd3, 8'h50, "R5 second write ANDs");
    erase();
    rdCmd(13'd3, 8'hFF, "R4 erase fills FF");

    // R8: data polling
    wrCmd(13'd7, 8'h3C, 1'b1);
    rdCmd(13'd7, 8'hBC, "R8 poll inverts MSB");
    rdCmd(13'd9, 8'hFF, "R8 other address normal while busy");
    repeat (BUSY + 200) @(negedge clk);
    rdCmd(13'd7, 8'h3C, "R8 normal after busy");

    // R7: commands refused while busy
    wrCmd(13'd11, 8'h11, 1'b1);
    wrCmd(13'd10, 8'h00, 1'b0);
    repeat (BUSY + 200) @(negedge clk);
    rdCmd(13'd10, 8'hFF, "R7 write during busy ignored");
    wrCmd(13'd12, 8'h22, 1'b1);
    frame(8'hAC, 8'h80, 8'h00, 8'h00); // ignored erase
    repeat (BUSY + 200) @(negedge clk);
    rdCmd(13'd12, 8'h22, "R7 erase during busy ignored");

    // R9: aliasing
    wrCmd(13'h1004, 8'h77, 1'b1);
    repeat (BUSY + 200) @(negedge clk);
    rdCmd(13'd4, 8'h77, "R9 high address aliases");

    // R1: partial frame discarded, unlock cleared
    rdGot = 8'h00;
    shiftBits(32'h40000400, 16);
    progMode = 1'b0;
    repeat (20) @(negedge clk);
    check8("R1 miso low when session off", {7'd0, miso}, 8'h00);
    progMode = 1'b1;
    repeat (5) @(negedge clk);
    rdCmd(13'd4, 8'h00, "R1 unlock cleared by session drop");
    frame(8'hAC, 8'h53, 8'h00, 8'h00);
    rdCmd(13'd4, 8'h77, "R1 frame alignment after drop");

    // random phase against the model (R5, R6, R9, R4)
    erase();
    for (int n = 0; n < 40; n++) begin
      int unsigned op;
      logic [12:0] a;
      logic [7:0] d;
      op = $urandom_range(0, 7);
      a = 13'($urandom);
      d = 8'($urandom);
      if (op == 0) erase();
      else if (op < 4) begin
        wrCmd(a, d, 1'b1);
        repeat (BUSY + 200) @(negedge clk);
      end else rdCmd(a, model[idxOf(a)], "R5 random read vs model");
    end

    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule